// File: doc/BRIEF.md
# Switch Control Register Target with Plug Interrupt

This block is a serial-bus (I2C) target that holds the two control and status bytes of a four-input video switch. A host addresses it with a 7-bit address. The top five bits of that address are fixed, and the low two bits come from strap pins. In one transaction the host writes or reads the two bytes, first byte 0 and then byte 1. The rest of the chip receives both bytes in parallel and uses them to configure the switch.

The block also watches four connector-power inputs, one for each video port. Byte 1 shows the synchronized level of each input. Any rising or falling edge on any input sets a sticky interrupt flag. That flag appears in byte 1 and on a dedicated output pin. It stays set until the host has read byte 1 over the bus.

SCL and SDA are sampled with the system clock. SDA is open drain: the block only ever pulls it low.

Top module: `i2c_switch_regs`

## Requirements
- R1: The target acknowledges an address byte whose upper seven bits equal 1,0,1,0,1 followed by the two strap bits (strap bit 1 first). Bit 0 of that byte is the direction: 0 means write and 1 means read. On any other address, SDA stays released for the whole transfer.
- R2: In a write, the first data byte lands in byte 0 and the second lands in byte 1. Each of these two bytes is acknowledged.
- R3: A third or later data byte in a write is not acknowledged, and it changes neither register.
- R4: In a read, the target returns byte 0 first, then byte 1, and then 0xFF for any further byte. Every read and every write starts again at byte 0.
- R5: After reset, byte 0 is 0x00, byte 1 is 0x40 (only bit 6 set), and the interrupt output is low.
- R6: Byte 1 bits 5, 4, 3 and 2 show the presence inputs of ports 3, 2, 1 and 0. The value 1 means a port is connected. Each bit follows its input two clocks after the input changes.
- R7: Of byte 1, only bits 7, 6 and 0 can be written. Written values for bits 5 to 1 are ignored.
- R8: An edge in either direction on any presence input sets the flag (byte 1 bit 1) and the interrupt output within three clocks.
- R9: The flag clears when the eighth bit of byte 1 has been sent on a read. A read that stops after byte 0 leaves the flag set. If a new edge arrives in the same clock as the clear, the flag stays set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that samples the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| sda_oe | output | 1 | 1 pulls the data line low |
| addr_strap | input | 2 | Low two address bits |
| port_present | input | 4 | Connector-power detect, one bit per port |
| irq | output | 1 | Interrupt flag state |
| ctrl0 | output | 8 | Byte 0 contents |
| ctrl1 | output | 8 | Byte 1 contents, status bits included |

## Verification
The data line reacts about three clocks after each SCL edge. That delay comes from two synchronizer flops plus the output register. The bench therefore changes SDA eight clocks into the SCL low phase and reads the line eight clocks into the SCL high phase. A presence change shows in byte 1 two clocks later and in the interrupt output three clocks later, so the bench waits six clocks before it compares. Register outputs are compared only after the stop condition, once every byte has been committed.

// File: rtl/i2c_switch_regs.sv
module i2c_switch_regs #(
  parameter logic [4:0] ADDR_HI = 5'b10101
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_oe,
  input  logic [1:0] addr_strap,
  input  logic [3:0] port_present,
  output logic       irq,
  output logic [7:0] ctrl0,
  output logic [7:0] ctrl1
);

  typedef enum logic [2:0] {S_IDLE, S_ADDR, S_AACK, S_WR, S_WACK, S_RD, S_RACK} st_t;

  st_t        state;
  logic [2:0] scl_q, sda_q;
  logic [3:0] p1, p2, p3;
  logic [3:0] bitcnt;
  logic [7:0] shreg;
  logic [1:0] idx;
  logic       rw, mack_n, sda_drv, flag;
  logic [7:0] r0;
  logic [2:0] r1w;
  logic [7:0] rd_byte;

  wire scl_rise = scl_q[1] & ~scl_q[2];
  wire scl_fall = ~scl_q[1] & scl_q[2];
  wire start    = scl_q[1] & scl_q[2] & sda_q[2] & ~sda_q[1];
  wire stop     = scl_q[1] & scl_q[2] & ~sda_q[2] & sda_q[1];
  wire edge_any = |(p2 ^ p3);
  wire rd_clr   = scl_fall && state == S_RD && bitcnt == 4'd8 && idx == 2'd1;

  assign ctrl0  = r0;
  assign ctrl1  = {r1w[2:1], p2, flag, r1w[0]};
  assign irq    = flag;
  assign sda_oe = sda_drv;
  assign rd_byte = (idx == 2'd0) ? r0 : (idx == 2'd1) ? ctrl1 : 8'hFF;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      scl_q <= 3'b111;
      sda_q <= 3'b111;
      p1 <= '0; p2 <= '0; p3 <= '0;
    end else begin
      scl_q <= {scl_q[1:0], scl_i};
      sda_q <= {sda_q[1:0], sda_i};
      p1 <= port_present; p2 <= p1; p3 <= p2;
    end

  // flag: a new edge wins over the read clear
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)        flag <= 1'b0;
    else if (edge_any) flag <= 1'b1;
    else if (rd_clr)   flag <= 1'b0;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      state <= S_IDLE; bitcnt <= '0; shreg <= '0; idx <= '0;
      rw <= 1'b0; mack_n <= 1'b1; sda_drv <= 1'b0;
      r0 <= 8'h00; r1w <= 3'b010;
    end else if (start) begin
      state <= S_ADDR; bitcnt <= '0; idx <= '0; sda_drv <= 1'b0;
    end else if (stop) begin
      state <= S_IDLE; sda_drv <= 1'b0;
    end else if (scl_rise) begin
      case (state)
        S_ADDR, S_WR: begin
          shreg  <= {shreg[6:0], sda_q[1]};
          bitcnt <= bitcnt + 4'd1;
        end
        S_RACK: mack_n <= sda_q[1];
        default: ;
      endcase
    end else if (scl_fall) begin
      case (state)
        S_ADDR:
          if (bitcnt == 4'd8) begin
            if (shreg[7:1] == {ADDR_HI, addr_strap}) begin
              sda_drv <= 1'b1; rw <= shreg[0]; state <= S_AACK;
            end else state <= S_IDLE;
          end
        S_AACK: begin
          bitcnt <= '0;
          if (rw) begin
            sda_drv <= ~rd_byte[7];
            shreg   <= {rd_byte[6:0], 1'b0};
            bitcnt  <= 4'd1;
            state   <= S_RD;
          end else begin
            sda_drv <= 1'b0;
            state   <= S_WR;
          end
        end
        S_WR:
          if (bitcnt == 4'd8) begin
            if (idx == 2'd0) r0 <= shreg;
            if (idx == 2'd1) r1w <= {shreg[7], shreg[6], shreg[0]};
            sda_drv <= (idx != 2'd2);
            if (idx != 2'd2) idx <= idx + 2'd1;
            state <= S_WACK;
          end
        S_WACK: begin
          sda_drv <= 1'b0; bitcnt <= '0; state <= S_WR;
        end
        S_RD:
          if (bitcnt == 4'd8) begin
            sda_drv <= 1'b0;
            if (idx != 2'd2) idx <= idx + 2'd1;
            state <= S_RACK;
          end else begin
            sda_drv <= ~shreg[7];
            shreg   <= {shreg[6:0], 1'b0};
            bitcnt  <= bitcnt + 4'd1;
          end
        S_RACK:
          if (mack_n) state <= S_IDLE;
          else begin
            sda_drv <= ~rd_byte[7];
            shreg   <= {rd_byte[6:0], 1'b0};
            bitcnt  <= 4'd1;
            state   <= S_RD;
          end
        default: ;
      endcase
    end

  // R8
  flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (p2 != p3) |=> irq);

  // R9
  flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq) |-> $past(state == S_RD && bitcnt == 4'd8 && idx == 2'd1 && scl_fall));

  // R2
  byte0_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ctrl0) |-> $past(state == S_WR && scl_fall && bitcnt == 4'd8));

  // R1
  sda_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sda_oe |-> (state == S_AACK || state == S_WACK || state == S_RD));

  // R7
  ctl_hi_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ctrl1[7:6]) |-> $past(state == S_WR && scl_fall && idx == 2'd1));

endmodule

// File: tb/tb_i2c_switch_regs.sv
module tb_i2c_switch_regs;
  localparam int Q = 8;
  logic clk = 1'b0, rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic sda_oe, irq;
  logic [1:0] strap = 2'b10;
  logic [3:0] pres = 4'h0;
  logic [7:0] ctrl0, ctrl1;
  wire bus_sda = sda_m & ~sda_oe;
  int checks = 0, fails = 0;
  bit done = 0;

  always #2 clk = ~clk;

  i2c_switch_regs dut (.clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(bus_sda),
    .sda_oe(sda_oe), .addr_strap(strap), .port_present(pres), .irq(irq),
    .ctrl0(ctrl0), .ctrl1(ctrl1));

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wq(); repeat (Q) @(negedge clk); endtask

  task automatic i2c_start();
    sda_m = 1; scl_m = 1; wq(); sda_m = 0; wq(); scl_m = 0; wq();
  endtask

  task automatic i2c_stop();
    sda_m = 0; wq(); scl_m = 1; wq(); sda_m = 1; wq(); wq();
  endtask

  task automatic i2c_bit(input logic b, output logic s);
    sda_m = b; wq(); scl_m = 1; wq(); s = bus_sda; wq(); scl_m = 0; wq();
  endtask

  task automatic put_byte(input logic [7:0] d, output logic ack);
    logic s;
    for (int i = 7; i >= 0; i--) i2c_bit(d[i], s);
    i2c_bit(1'b1, s);
    ack = ~s;
  endtask

  task automatic get_byte(input logic give_ack, output logic [7:0] d);
    logic s;
    for (int i = 7; i >= 0; i--) begin i2c_bit(1'b1, s); d[i] = s; end
    i2c_bit(~give_ack, s);
  endtask

  function automatic logic [7:0] addr(input logic [1:0] a, input logic r);
    return {5'b10101, a, r};
  endfunction

  task automatic write_n(input int n, input logic [7:0] b0, input logic [7:0] b1,
                         input logic [7:0] b2, output logic [2:0] acks);
    logic a;
    acks = '0;
    i2c_start();
    put_byte(addr(strap, 1'b0), a);
    if (n > 0) put_byte(b0, acks[0]);
    if (n > 1) put_byte(b1, acks[1]);
    if (n > 2) put_byte(b2, acks[2]);
    i2c_stop();
  endtask

  task automatic read_n(input int n, output logic [7:0] d0, output logic [7:0] d1,
                        output logic [7:0] d2);
    logic a;
    d0 = '0; d1 = '0; d2 = '0;
    i2c_start();
    put_byte(addr(strap, 1'b1), a);
    if (n > 0) get_byte(n > 1, d0);
    if (n > 1) get_byte(n > 2, d1);
    if (n > 2) get_byte(1'b0, d2);
    i2c_stop();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic a;
    logic [2:0] acks;
    logic [7:0] d0, d1, d2;
    logic [3:0] prevp;
    repeat (5) @(negedge clk);
    rst_n = 1;
    repeat (5) @(negedge clk);
    // R5 reset state
    chk("R5 ctrl0", ctrl0, 8'h00);
    chk("R5 ctrl1", ctrl1, 8'h40);
    chk("R5 irq", irq, 0);

    // R1 sweep of strap and addressed value
    for (int s = 0; s < 4; s++) begin
      for (int t = 0; t < 4; t++) begin
        strap = s[1:0];
        repeat (4) @(negedge clk);
        i2c_start();
        put_byte(addr(t[1:0], 1'b0), a);
        i2c_stop();
        chk("R1 addr ack", a, (s == t) ? 1 : 0);
      end
    end
    strap = 2'b10;
    repeat (4) @(negedge clk);
    i2c_start(); put_byte({5'b10111, strap, 1'b0}, a); i2c_stop();
    chk("R1 prefix mismatch", a, 0);
    chk("R1 mismatch no write", ctrl0, 8'h00);

    // R2 R7 R4 write/read patterns
    for (int k = 0; k < 6; k++) begin
      logic [7:0] w0, w1;
      w0 = 8'(k * 8'h35 + 8'h1B);
      w1 = 8'(8'hFF - k * 8'h2D);
      write_n(2, w0, w1, 8'h00, acks);
      chk("R2 ack byte0", acks[0], 1);
      chk("R2 ack byte1", acks[1], 1);
      chk("R2 ctrl0", ctrl0, w0);
      // R7 bits 5..1 not written
      chk("R7 ctrl1", ctrl1, {w1[7:6], 4'h0, 1'b0, w1[0]});
      read_n(2, d0, d1, d2);
      chk("R4 read byte0", d0, w0);
      chk("R4 read byte1", d1, {w1[7:6], 4'h0, 1'b0, w1[0]});
    end

    // R3 third write byte
    write_n(3, 8'hA5, 8'h41, 8'h3C, acks);
    chk("R3 third nack", acks[2], 0);
    chk("R3 ctrl0 kept", ctrl0, 8'hA5);
    chk("R3 ctrl1 kept", ctrl1, 8'h41);
    // R4 third read byte
    read_n(3, d0, d1, d2);
    chk("R4 first byte", d0, 8'hA5);
    chk("R4 third byte", d2, 8'hFF);

    // R6 R8 R9 presence sweep
    prevp = 4'h0;
    for (int v = 0; v < 16; v++) begin
      pres = v[3:0];
      repeat (6) @(negedge clk);
      chk("R6 status bits", ctrl1[5:2], v);
      chk("R8 irq on edge", irq, (v[3:0] != prevp) ? 1 : 0);
      if (irq) begin
        read_n(1, d0, d1, d2);
        chk("R9 byte0-only read keeps flag", irq, 1);
        read_n(2, d0, d1, d2);
        chk("R9 flag read as set", d1[1], 1);
        chk("R6 read status", d1[5:2], v);
        chk("R9 flag cleared", irq, 0);
      end
      prevp = v[3:0];
    end
    // R7 write ones into status and flag bits
    pres = 4'h0;
    repeat (6) @(negedge clk);
    read_n(2, d0, d1, d2);
    write_n(2, 8'h00, 8'hFF, 8'h00, acks);
    chk("R7 ro bits ignored", ctrl1, 8'hC1);
    chk("R7 irq unchanged", irq, 0);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule